// File: doc/BRIEF.md
# Dual-Bus Command Retry Sequencer

This block is the transaction engine of a bus controller on a dual-redundant, 1 Mbit/s command/response bus. A host hands it one transfer at a time: the transfer kind, the target terminal address and subaddress, a word count and the bus on which to try first. The sequencer then produces the command words, and any outbound data words, on a word-level transmit interface. It waits for each word's end-of-transmission strobe before it moves on. After that it listens on a word-level receive interface for the status and data words it expects back.

Three transfer kinds are sequenced: controller to terminal, terminal to controller, and terminal to terminal. In the last kind the controller issues two commands and then waits for the source's status and data, followed by the destination's status. If an expected word does not begin within 14 µs, the whole transaction is repeated once on the other bus. A second silence ends the transfer with a failure, and no third attempt is made. The completion report gives the outcome, the bus that carried the final attempt, and whether the retry was used. Line encoding, coupling, monitoring and terminal emulation sit in other blocks.

Top module: `bc_retry_seq`

## Requirements
- R1: After reset `busy`, `done` and `tx_valid` are 0, and the sequencer transmits only while a transfer it accepted is in progress. Each word is offered by a one-cycle `tx_valid` pulse, and the next word waits for `tx_done`.
- R2: A `start` while idle is ignored when `req_kind` is 3 (reserved), when `req_rt` is 31, or when a terminal-to-terminal request has `req_rt2` equal to 31. No word is sent, `busy` stays 0 and no `done` follows. Valid targets are addresses 0 to 30.
- R3: A command word is `{address[4:0], tr, subaddress[4:0], count[4:0]}` with bit 15 as the most significant address bit. `tr`=1 means the terminal transmits. Command words are sent with `tx_sync_cmd`=1 and data words with `tx_sync_cmd`=0.
- R4: A controller-to-terminal transfer (`req_kind`=0) sends one command with `tr`=0, then N data words, then expects one status word. N equals the count, and a count of 0 means 32. Data word k is the value on `dat_word` while `dat_idx`=k.
- R5: A terminal-to-controller transfer (`req_kind`=1) sends one command with `tr`=1, then expects a status word followed by N data words.
- R6: A terminal-to-terminal transfer (`req_kind`=2) first sends a receive command (`tr`=0) to `req_rt`/`req_sa`, then a transmit command (`tr`=1) to `req_rt2`/`req_sa2`, both carrying the same count. It then expects the source's status, N data words and the destination's status.
- R7: An attempt fails when no word starts (`rx_start` on the active bus) within TIMEOUT_US·CLK_PER_US clock cycles (14 µs). The window is measured from the end of the last transmitted word (`tx_done`) or the last received word (`rx_valid`). A word that starts before the limit is accepted.
- R8: A failed first attempt is repeated from its first command on the other bus, and the retry starts on the cycle after the timeout.
- R9: If the retry also fails, `done` pulses with `done_ok`=0 and `busy` falls. No further word is transmitted.
- R10: Completion raises `done` for one cycle, together with `done_ok`, `done_bus` (0 = bus A, 1 = bus B, the bus of the final attempt) and `done_retry`. These report values hold until the next completion.
- R11: `rx_start` and `rx_valid` on the bus not in use for the current attempt have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted while idle |
| req_kind | input | 2 | 0 ctrl→term, 1 term→ctrl, 2 term→term, 3 reserved |
| req_bus | input | 1 | Bus of the first attempt (0 = A, 1 = B) |
| req_rt | input | 5 | Target address (destination for term→term) |
| req_sa | input | 5 | Subaddress for the first command |
| req_rt2 | input | 5 | Source address for term→term |
| req_sa2 | input | 5 | Source subaddress for term→term |
| req_wc | input | 5 | Word count, 0 means 32 |
| dat_idx | output | 5 | Index of the outbound data word being requested |
| dat_word | input | 16 | Outbound data word for index `dat_idx` |
| tx_valid | output | 1 | One-cycle strobe: transmit `tx_word` |
| tx_bus | output | 1 | Bus for the word being transmitted |
| tx_sync_cmd | output | 1 | 1 = command sync, 0 = data sync |
| tx_word | output | 16 | Word to transmit |
| tx_done | input | 1 | Transmitter finished the current word |
| rx_start | input | 1 | A received word has begun |
| rx_valid | input | 1 | A received word has ended |
| rx_bus | input | 1 | Bus on which `rx_start`/`rx_valid` occurred |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion strobe |
| done_ok | output | 1 | Last transfer succeeded |
| done_bus | output | 1 | Bus of the final attempt |
| done_retry | output | 1 | Last transfer needed the alternate bus |

## Verification
Several properties are checked on every cycle: transmission happens only while busy, rejected requests never raise `busy`, and `done` is a single-cycle pulse seen only when idle. The reported bus must differ from the requested one exactly when the retry was used, and a failure always implies that a retry took place. Other behaviour shows up only in the bench's scenarios. These include the exact content and order of command and data words for each transfer kind, the 32-word case, the exact cycle at which the timeout fires, acceptance of a reply that starts just inside the window, a timeout that strikes in the middle of a data burst, and replies on the idle bus being ignored.

// File: rtl/brs_pkg.sv
package brs_pkg;

   typedef enum logic [1:0] {
      K_BC2RT = 2'd0,
      K_RT2BC = 2'd1,
      K_RT2RT = 2'd2,
      K_RSVD  = 2'd3
   } kind_e;

   typedef enum logic [2:0] {
      STP_CMD0  = 3'd0,
      STP_CMD1  = 3'd1,
      STP_TXDAT = 3'd2,
      STP_STAT1 = 3'd3,
      STP_RXDAT = 3'd4,
      STP_STAT2 = 3'd5
   } step_e;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_XMIT   = 2'd1,
      PH_LISTEN = 2'd2
   } phase_e;

endpackage

// File: rtl/brs_timeout.sv
module brs_timeout #(
   parameter int CLK_PER_US = 16,
   parameter int TIMEOUT_US = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic expired
);
   localparam int US_W = $clog2(TIMEOUT_US + 1);
   localparam logic [US_W-1:0] US_LIM = US_W'(TIMEOUT_US);

   logic            tick;
   logic [US_W-1:0] us_q;

   generate
      if (CLK_PER_US == 1) begin : g_no_pre
         assign tick = arm;
      end else begin : g_pre
         localparam int PRE_W = $clog2(CLK_PER_US);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (!arm) begin
               pre_q <= '0;
            end else if (pre_q == PRE_LAST) begin
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end
         assign tick = arm && (pre_q == PRE_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         us_q <= '0;
      end else if (!arm) begin
         us_q <= '0;
      end else if (tick && (us_q != US_LIM)) begin
         us_q <= us_q + 1'b1;
      end
   end

   assign expired = arm && (us_q == US_LIM);

endmodule

// File: rtl/brs_wordgen.sv
module brs_wordgen
   import brs_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int SA_W   = 5,
   parameter int WC_W   = 5,
   parameter int WORD_W = 16
) (
   input  step_e              step,
   input  kind_e              kind,
   input  logic [ADDR_W-1:0]  rt,
   input  logic [SA_W-1:0]    sa,
   input  logic [ADDR_W-1:0]  rt2,
   input  logic [SA_W-1:0]    sa2,
   input  logic [WC_W-1:0]    wc,
   input  logic [WORD_W-1:0]  dat_word,
   output logic [WORD_W-1:0]  word,
   output logic               is_cmd
);
   always_comb begin
      word   = '0;
      is_cmd = 1'b1;
      case (step)
         STP_CMD0:  word = {rt, (kind == K_RT2BC), sa, wc};
         STP_CMD1:  word = {rt2, 1'b1, sa2, wc};
         STP_TXDAT: begin
            word   = dat_word;
            is_cmd = 1'b0;
         end
         default:   word = '0;
      endcase
   end

endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
   import brs_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int SA_W   = 5,
   parameter int WC_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [1:0]         req_kind,
   input  logic               req_bus,
   input  logic [ADDR_W-1:0]  req_rt,
   input  logic [SA_W-1:0]    req_sa,
   input  logic [ADDR_W-1:0]  req_rt2,
   input  logic [SA_W-1:0]    req_sa2,
   input  logic [WC_W-1:0]    req_wc,
   input  logic               tx_done,
   input  logic               rx_start,
   input  logic               rx_valid,
   input  logic               rx_bus,
   input  logic               expired,
   output step_e              step_q,
   output kind_e              kind_q,
   output logic [ADDR_W-1:0]  rt_q,
   output logic [SA_W-1:0]    sa_q,
   output logic [ADDR_W-1:0]  rt2_q,
   output logic [SA_W-1:0]    sa2_q,
   output logic [WC_W-1:0]    wc_q,
   output logic [WC_W-1:0]    dat_idx,
   output logic               bus_q,
   output logic               tx_valid,
   output logic               arm,
   output logic               busy,
   output logic               done,
   output logic               done_ok,
   output logic               done_bus,
   output logic               done_retry
);
   localparam int CNT_W = WC_W + 1;
   localparam logic [ADDR_W-1:0] BCAST = {ADDR_W{1'b1}};
   localparam logic [CNT_W-1:0]  FULL  = CNT_W'(2 ** WC_W);

   phase_e           ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic             retry_q;
   logic             got_q;
   logic             tx_valid_q;
   logic             done_q, ok_q, dbus_q, dretry_q;

   logic [CNT_W-1:0] nwords;
   logic             last_word;
   logic             accept, adv, rx_sof, rx_end, lost;
   step_e            nx_step;
   logic [CNT_W-1:0] nx_cnt;
   logic             nx_listen, nx_fin;

   assign nwords    = (wc_q == '0) ? FULL : {1'b0, wc_q};
   assign last_word = ((cnt_q + CNT_W'(1)) == nwords);

   assign accept = (ph_q == PH_IDLE) && start &&
                   (req_kind != K_RSVD) && (req_rt != BCAST) &&
                   !((req_kind == K_RT2RT) && (req_rt2 == BCAST));

   assign rx_sof = (ph_q == PH_LISTEN) && rx_start && (rx_bus == bus_q);
   assign rx_end = (ph_q == PH_LISTEN) && rx_valid && (rx_bus == bus_q);
   assign adv    = ((ph_q == PH_XMIT) && tx_done) || rx_end;
   assign arm    = (ph_q == PH_LISTEN) && !got_q;
   assign lost   = arm && expired && !rx_sof && !rx_end;

   // Step sequencing per transfer kind
   always_comb begin
      nx_step   = step_q;
      nx_cnt    = cnt_q;
      nx_listen = 1'b0;
      nx_fin    = 1'b0;
      case (step_q)
         STP_CMD0: begin
            case (kind_q)
               K_BC2RT: begin nx_step = STP_TXDAT; nx_cnt = '0; end
               K_RT2RT: nx_step = STP_CMD1;
               default: begin nx_step = STP_STAT1; nx_listen = 1'b1; end
            endcase
         end
         STP_CMD1: begin
            nx_step   = STP_STAT1;
            nx_listen = 1'b1;
         end
         STP_TXDAT: begin
            if (last_word) begin
               nx_step   = STP_STAT1;
               nx_listen = 1'b1;
            end else begin
               nx_cnt = cnt_q + CNT_W'(1);
            end
         end
         STP_STAT1: begin
            if (kind_q == K_BC2RT) begin
               nx_fin = 1'b1;
            end else begin
               nx_step   = STP_RXDAT;
               nx_cnt    = '0;
               nx_listen = 1'b1;
            end
         end
         STP_RXDAT: begin
            if (!last_word) begin
               nx_cnt    = cnt_q + CNT_W'(1);
               nx_listen = 1'b1;
            end else if (kind_q == K_RT2RT) begin
               nx_step   = STP_STAT2;
               nx_listen = 1'b1;
            end else begin
               nx_fin = 1'b1;
            end
         end
         default: nx_fin = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= PH_IDLE;
         step_q     <= STP_CMD0;
         kind_q     <= K_BC2RT;
         cnt_q      <= '0;
         rt_q       <= '0;
         sa_q       <= '0;
         rt2_q      <= '0;
         sa2_q      <= '0;
         wc_q       <= '0;
         bus_q      <= 1'b0;
         retry_q    <= 1'b0;
         got_q      <= 1'b0;
         tx_valid_q <= 1'b0;
         done_q     <= 1'b0;
         ok_q       <= 1'b0;
         dbus_q     <= 1'b0;
         dretry_q   <= 1'b0;
      end else begin
         tx_valid_q <= 1'b0;
         done_q     <= 1'b0;
         if (accept) begin
            kind_q     <= kind_e'(req_kind);
            rt_q       <= req_rt;
            sa_q       <= req_sa;
            rt2_q      <= req_rt2;
            sa2_q      <= req_sa2;
            wc_q       <= req_wc;
            bus_q      <= req_bus;
            retry_q    <= 1'b0;
            got_q      <= 1'b0;
            step_q     <= STP_CMD0;
            cnt_q      <= '0;
            ph_q       <= PH_XMIT;
            tx_valid_q <= 1'b1;
         end else if (adv) begin
            got_q <= 1'b0;
            if (nx_fin) begin
               ph_q     <= PH_IDLE;
               done_q   <= 1'b1;
               ok_q     <= 1'b1;
               dbus_q   <= bus_q;
               dretry_q <= retry_q;
            end else begin
               step_q     <= nx_step;
               cnt_q      <= nx_cnt;
               ph_q       <= nx_listen ? PH_LISTEN : PH_XMIT;
               tx_valid_q <= !nx_listen;
            end
         end else if (lost) begin
            if (!retry_q) begin
               retry_q    <= 1'b1;
               bus_q      <= !bus_q;
               step_q     <= STP_CMD0;
               cnt_q      <= '0;
               ph_q       <= PH_XMIT;
               tx_valid_q <= 1'b1;
            end else begin
               ph_q     <= PH_IDLE;
               done_q   <= 1'b1;
               ok_q     <= 1'b0;
               dbus_q   <= bus_q;
               dretry_q <= 1'b1;
            end
         end else if (rx_sof) begin
            got_q <= 1'b1;
         end
      end
   end

   assign dat_idx    = cnt_q[WC_W-1:0];
   assign tx_valid   = tx_valid_q;
   assign busy       = (ph_q != PH_IDLE);
   assign done       = done_q;
   assign done_ok    = ok_q;
   assign done_bus   = dbus_q;
   assign done_retry = dretry_q;

endmodule

// File: rtl/bc_retry_seq.sv
module bc_retry_seq
   import brs_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int SA_W       = 5,
   parameter int WC_W       = 5,
   parameter int WORD_W     = 16,
   parameter int CLK_PER_US = 16,
   parameter int TIMEOUT_US = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [1:0]         req_kind,
   input  logic               req_bus,
   input  logic [ADDR_W-1:0]  req_rt,
   input  logic [SA_W-1:0]    req_sa,
   input  logic [ADDR_W-1:0]  req_rt2,
   input  logic [SA_W-1:0]    req_sa2,
   input  logic [WC_W-1:0]    req_wc,
   output logic [WC_W-1:0]    dat_idx,
   input  logic [WORD_W-1:0]  dat_word,
   output logic               tx_valid,
   output logic               tx_bus,
   output logic               tx_sync_cmd,
   output logic [WORD_W-1:0]  tx_word,
   input  logic               tx_done,
   input  logic               rx_start,
   input  logic               rx_valid,
   input  logic               rx_bus,
   output logic               busy,
   output logic               done,
   output logic               done_ok,
   output logic               done_bus,
   output logic               done_retry
);
   generate
      if (WORD_W != ADDR_W + 1 + SA_W + WC_W) begin : g_bad_fmt
         $error("command fields do not fill the word width");
      end
      if (CLK_PER_US < 1 || TIMEOUT_US < 1) begin : g_bad_time
         $error("timing parameters must be positive");
      end
   endgenerate

   step_e              step_q;
   kind_e              kind_q;
   logic [ADDR_W-1:0]  rt_q, rt2_q;
   logic [SA_W-1:0]    sa_q, sa2_q;
   logic [WC_W-1:0]    wc_q;
   logic               arm, expired;

   brs_ctrl #(
      .ADDR_W(ADDR_W), .SA_W(SA_W), .WC_W(WC_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_kind(req_kind), .req_bus(req_bus),
      .req_rt(req_rt), .req_sa(req_sa), .req_rt2(req_rt2), .req_sa2(req_sa2),
      .req_wc(req_wc), .tx_done(tx_done),
      .rx_start(rx_start), .rx_valid(rx_valid), .rx_bus(rx_bus),
      .expired(expired),
      .step_q(step_q), .kind_q(kind_q),
      .rt_q(rt_q), .sa_q(sa_q), .rt2_q(rt2_q), .sa2_q(sa2_q), .wc_q(wc_q),
      .dat_idx(dat_idx), .bus_q(tx_bus), .tx_valid(tx_valid), .arm(arm),
      .busy(busy), .done(done), .done_ok(done_ok),
      .done_bus(done_bus), .done_retry(done_retry)
   );

   brs_timeout #(
      .CLK_PER_US(CLK_PER_US), .TIMEOUT_US(TIMEOUT_US)
   ) u_tmo (
      .clk(clk), .rst_n(rst_n), .arm(arm), .expired(expired)
   );

   brs_wordgen #(
      .ADDR_W(ADDR_W), .SA_W(SA_W), .WC_W(WC_W), .WORD_W(WORD_W)
   ) u_wgen (
      .step(step_q), .kind(kind_q),
      .rt(rt_q), .sa(sa_q), .rt2(rt2_q), .sa2(sa2_q), .wc(wc_q),
      .dat_word(dat_word), .word(tx_word), .is_cmd(tx_sync_cmd)
   );

endmodule

// File: rtl/brs_chk.sv
module brs_chk #(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [1:0]        req_kind,
   input logic [ADDR_W-1:0] req_rt,
   input logic [ADDR_W-1:0] req_rt2,
   input logic              req_bus,
   input logic              tx_valid,
   input logic              busy,
   input logic              done,
   input logic              done_ok,
   input logic              done_bus,
   input logic              done_retry
);
   localparam logic [ADDR_W-1:0] BCAST = {ADDR_W{1'b1}};

   logic first_bus_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              first_bus_q <= 1'b0;
      else if (start && !busy) first_bus_q <= req_bus;
   end

   a_r1_tx_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> busy);

   a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (req_kind == 2'd3 || req_rt == BCAST ||
                          (req_kind == 2'd2 && req_rt2 == BCAST))) |=> !busy);

   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_retry_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_retry) |-> (done_bus != first_bus_q));

   a_r8_first_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_retry) |-> (done_bus == first_bus_q));

   a_r9_fail_after_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_ok) |-> done_retry);

endmodule

bind bc_retry_seq brs_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .req_kind(req_kind),
   .req_rt(req_rt), .req_rt2(req_rt2), .req_bus(req_bus),
   .tx_valid(tx_valid), .busy(busy), .done(done), .done_ok(done_ok),
   .done_bus(done_bus), .done_retry(done_retry)
);

// File: tb/tb_bc_retry_seq.sv
module tb_bc_retry_seq;
   localparam int CPU      = 4;
   localparam int TMO      = 14;
   localparam int WORD_CYC = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  req_kind = '0;
   logic        req_bus = 1'b0;
   logic [4:0]  req_rt = '0, req_sa = '0, req_rt2 = '0, req_sa2 = '0, req_wc = '0;
   logic [4:0]  dat_idx;
   logic [15:0] dat_word;
   logic        tx_valid, tx_bus, tx_sync_cmd;
   logic [15:0] tx_word;
   logic        tx_done = 1'b0;
   logic        rx_start = 1'b0, rx_valid = 1'b0, rx_bus = 1'b0;
   logic        busy, done, done_ok, done_bus, done_retry;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   assign dat_word = 16'hC3E0 ^ {11'd0, dat_idx};

   bc_retry_seq #(.CLK_PER_US(CPU), .TIMEOUT_US(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .req_kind(req_kind),
      .req_bus(req_bus), .req_rt(req_rt), .req_sa(req_sa), .req_rt2(req_rt2),
      .req_sa2(req_sa2), .req_wc(req_wc), .dat_idx(dat_idx), .dat_word(dat_word),
      .tx_valid(tx_valid), .tx_bus(tx_bus), .tx_sync_cmd(tx_sync_cmd),
      .tx_word(tx_word), .tx_done(tx_done), .rx_start(rx_start),
      .rx_valid(rx_valid), .rx_bus(rx_bus), .busy(busy), .done(done),
      .done_ok(done_ok), .done_bus(done_bus), .done_retry(done_retry)
   );

   typedef struct packed {
      logic [1:0] kind;
      logic       bus;
      logic [4:0] rt;
      logic [4:0] sa;
      logic [4:0] rt2;
      logic [4:0] sa2;
      logic [4:0] wc;
      logic [1:0] resp;   // bit0: terminal answers on bus A, bit1: on bus B
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{2'd0, 1'b0, 5'd5,  5'd3,  5'd0, 5'd0, 5'd2, 2'b11},
      '{2'd1, 1'b1, 5'd30, 5'd1,  5'd0, 5'd0, 5'd4, 2'b01},
      '{2'd2, 1'b0, 5'd7,  5'd2,  5'd9, 5'd4, 5'd3, 2'b11},
      '{2'd0, 1'b1, 5'd0,  5'd31, 5'd0, 5'd0, 5'd0, 2'b10},
      '{2'd1, 1'b0, 5'd12, 5'd5,  5'd0, 5'd0, 5'd1, 2'b00},
      '{2'd2, 1'b1, 5'd1,  5'd7,  5'd2, 5'd8, 5'd1, 2'b01}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] k, input logic b, input logic [4:0] rt,
                        input logic [4:0] sa, input logic [4:0] rt2,
                        input logic [4:0] sa2, input logic [4:0] wc);
      @(negedge clk);
      req_kind = k; req_bus = b; req_rt = rt; req_sa = sa;
      req_rt2 = rt2; req_sa2 = sa2; req_wc = wc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Wait for a word offer, check it, model the word time, strobe tx_done
   task automatic expect_tx(input logic [15:0] w, input logic b, input logic c,
                            input string req);
      int lim = 0;
      while (!tx_valid && lim < 2000) begin @(negedge clk); lim++; end
      chk(tx_valid, req, "word offered", {31'd0, tx_valid}, 32'd1);
      if (tx_valid) begin
         chk(tx_word == w && tx_bus == b && tx_sync_cmd == c, req, "word/bus/sync",
             {14'd0, tx_bus, tx_sync_cmd, tx_word}, {14'd0, b, c, w});
         repeat (WORD_CYC) @(negedge clk);
         tx_done = 1'b1;
         @(negedge clk);
         tx_done = 1'b0;
      end
   endtask

   task automatic give_rx(input logic b, input int gap);
      repeat (gap) @(negedge clk);
      rx_bus = b; rx_start = 1'b1;
      @(negedge clk);
      rx_start = 1'b0;
      repeat (4) @(negedge clk);
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic wait_done(input logic ok, input logic b, input logic r,
                            input string req);
      int lim = 0;
      while (!done && lim < 3000) begin @(negedge clk); lim++; end
      chk(done, req, "done pulse", {31'd0, done}, 32'd1);
      chk(done_ok == ok && done_bus == b && done_retry == r && !busy, req,
          "report ok/bus/retry/busy", {28'd0, done_ok, done_bus, done_retry, busy},
          {28'd0, ok, b, r, 1'b0});
   endtask

   task automatic quiet(input int cyc, input string req);
      bit seen = 0;
      repeat (cyc) begin
         @(negedge clk);
         if (tx_valid || busy || done) seen = 1;
      end
      chk(!seen, req, "no activity", {31'd0, seen}, 32'd0);
   endtask

   function automatic logic [15:0] cmdw(input logic [4:0] a, input logic tr,
                                        input logic [4:0] s, input logic [4:0] c);
      return {a, tr, s, c};
   endfunction

   task automatic run_vec(input vec_t v);
      int nw = (v.wc == 0) ? 32 : int'(v.wc);
      logic fb = v.bus;
      logic ok = v.resp[0] | v.resp[1];
      logic ended = 0;
      issue(v.kind, v.bus, v.rt, v.sa, v.rt2, v.sa2, v.wc);
      for (int att = 0; att < 2; att++) begin
         logic b = fb ^ att[0];
         expect_tx(cmdw(v.rt, v.kind == 2'd1, v.sa, v.wc), b, 1'b1, "R3");
         if (v.kind == 2'd2) expect_tx(cmdw(v.rt2, 1'b1, v.sa2, v.wc), b, 1'b1, "R6");
         if (v.kind == 2'd0)
            for (int k = 0; k < nw; k++) expect_tx(16'hC3E0 ^ 16'(k), b, 1'b0, "R4");
         if (v.resp[b]) begin
            give_rx(b, 12);
            if (v.kind != 2'd0)
               for (int k = 0; k < nw; k++) give_rx(b, 4);
            if (v.kind == 2'd2) give_rx(b, 4);
            ended = 1;
            break;
         end
      end
      if (ended)
         wait_done(1'b1, v.resp[fb] ? fb : ~fb, !v.resp[fb], "R8");
      else
         wait_done(1'b0, ~fb, 1'b1, "R9");
      if (!ok) quiet(100, "R9");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !tx_valid, "R1", "reset outputs",
          {29'd0, busy, done, tx_valid}, 32'd0);
      rst_n = 1'b1;
      quiet(10, "R1");

      // Table of transfers across kinds, counts and bus outcomes
      for (int i = 0; i < 6; i++) run_vec(VECS[i]);

      // R2: reserved kind and address 31 are ignored
      issue(2'd3, 1'b0, 5'd3, 5'd1, 5'd0, 5'd0, 5'd1);
      quiet(30, "R2");
      issue(2'd0, 1'b0, 5'd31, 5'd1, 5'd0, 5'd0, 5'd1);
      quiet(30, "R2");
      issue(2'd2, 1'b1, 5'd4, 5'd1, 5'd31, 5'd2, 5'd1);
      quiet(30, "R2");

      // R7: status starting 13 us after the last word is still accepted
      issue(2'd0, 1'b0, 5'd6, 5'd9, 5'd0, 5'd0, 5'd1);
      expect_tx(cmdw(5'd6, 1'b0, 5'd9, 5'd1), 1'b0, 1'b1, "R4");
      expect_tx(16'hC3E0, 1'b0, 1'b0, "R4");
      give_rx(1'b0, 13 * CPU);
      wait_done(1'b1, 1'b0, 1'b0, "R7");

      // R7/R8: exact timeout cycle, retry restarts from the command on bus B
      issue(2'd1, 1'b0, 5'd2, 5'd3, 5'd0, 5'd0, 5'd1);
      expect_tx(cmdw(5'd2, 1'b1, 5'd3, 5'd1), 1'b0, 1'b1, "R5");
      cyc = 1;
      while (!tx_valid && cyc < 500) begin @(negedge clk); cyc++; end
      chk(cyc >= TMO * CPU + 1 && cyc <= TMO * CPU + 3, "R7", "retry delay",
          32'(cyc), 32'(TMO * CPU + 2));
      expect_tx(cmdw(5'd2, 1'b1, 5'd3, 5'd1), 1'b1, 1'b1, "R8");
      give_rx(1'b1, 8);
      give_rx(1'b1, 4);
      wait_done(1'b1, 1'b1, 1'b1, "R8");

      // R11: a reply on the idle bus is ignored and the retry still happens
      issue(2'd1, 1'b0, 5'd8, 5'd1, 5'd0, 5'd0, 5'd1);
      expect_tx(cmdw(5'd8, 1'b1, 5'd1, 5'd1), 1'b0, 1'b1, "R11");
      give_rx(1'b1, 8);
      give_rx(1'b1, 4);
      chk(!done && busy, "R11", "other-bus reply ignored",
          {30'd0, done, busy}, 32'd1);
      expect_tx(cmdw(5'd8, 1'b1, 5'd1, 5'd1), 1'b1, 1'b1, "R11");
      give_rx(1'b1, 8);
      give_rx(1'b1, 4);
      wait_done(1'b1, 1'b1, 1'b1, "R11");

      // R7: silence in the middle of a data burst also fails the attempt
      issue(2'd1, 1'b1, 5'd10, 5'd2, 5'd0, 5'd0, 5'd3);
      expect_tx(cmdw(5'd10, 1'b1, 5'd2, 5'd3), 1'b1, 1'b1, "R5");
      give_rx(1'b1, 8);
      give_rx(1'b1, 4);
      expect_tx(cmdw(5'd10, 1'b1, 5'd2, 5'd3), 1'b0, 1'b1, "R7");
      give_rx(1'b0, 8);
      for (int k = 0; k < 3; k++) give_rx(1'b0, 4);
      wait_done(1'b1, 1'b0, 1'b1, "R7");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule